// File: doc/BRIEF.md
# Delayed-Response Discard Timer

This block sits beside a bridge's delayed-transaction buffer and runs on the secondary (PCI) clock. When the response to a non-posted request arrives and is parked for the master that must retry, the buffer pulses an arm strobe. The block then counts clock cycles. If the master comes back and takes the response first, a taken strobe stops the count. If the count reaches its limit, the block pulses a discard output so the buffer can drop the stale response.

A small configuration register controls it. One field chooses a short or a long expiry window. A second field enables system-error reporting on expiry. A sticky status flag records that an expiry happened. The flag is set by hardware and cleared by writing one to it. It keeps its value through the ordinary bus reset and is cleared only by the power-good reset. A system-error request is raised on expiry only when the local enable and the global system-error enable from the command register are both set. That request also serves as the strobe that sets the signalled-system-error bit in the status register.

Top module: `dly_resp_discard_timer`

## Requirements
- R1: With the select field (register bit 0) at 1, discardPulse rises on the 2^SHORT_LOG2-th rising edge after the edge that samples respArm.
- R2: With the select field at 0, the window is 2^LONG_LOG2 edges, measured the same way.
- R3: discardPulse is high for exactly one cycle per expiry, and the timer is idle afterwards until the next arm.
- R4: A respTaken strobe returns the timer to idle with no discard. This holds even when it falls in the cycle in which the count would expire.
- R5: The status flag (register bit 2) reads 1 from the expiry edge on. Writing 1 to bit 2 clears it. Writing 0 to bit 2 leaves it unchanged.
- R6: busRstN clears the select and error-enable fields and the timer, but leaves the status flag as it is. pwrOkRstN clears everything, including the status flag.
- R7: sysErrReq pulses together with discardPulse only when the error-enable field (register bit 1) and globalSerrEn are both 1. Otherwise it stays low.
- R8: A write to the select field while a count is running does not change that count's window. The new value applies from the next arm.
- R9: respArm while the timer is running restarts the count from zero. When respArm coincides with a would-be expiry, the timer restarts and no discard occurs.
- R10: The register reads {bit3 = 0, bit2 = status, bit1 = error enable, bit0 = select}, and every bit reads 0 after power-good reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Secondary bus clock |
| pwrOkRstN | input | 1 | Power-good reset, active low; clears all state |
| busRstN | input | 1 | Ordinary bus reset, active low; keeps the status flag |
| respArm | input | 1 | Delayed response received; start or restart the count |
| respTaken | input | 1 | Retrying master took the response; stop the count |
| cfgWr | input | 1 | Register write strobe |
| cfgWrData | input | 4 | Write data; bit 2 is write-one-to-clear |
| cfgRdData | output | 4 | Register read data |
| globalSerrEn | input | 1 | System-error enable from the command register |
| discardPulse | output | 1 | One-cycle pulse: drop the pending response |
| sysErrReq | output | 1 | One-cycle system-error request; also sets the signalled-system-error bit |

## Verification
The bench builds the block with SHORT_LOG2 = 3 and LONG_LOG2 = 5, which gives windows of 8 and 32 cycles. At these sizes both windows can be timed to the exact edge in every enable combination. The short windows also make it cheap to place a stop or a re-arm on the precise expiry cycle, and to change the select field in the middle of a count. The 16-bit counter and its compare logic stay the same at the default sizes. Only the two limit constants change.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;     // zero the count and latch the window
    logic advance;  // count one cycle
  } dpCtrl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } timerState_t;

  localparam int REG_W     = 4;
  localparam int BIT_SHORT = 0;
  localparam int BIT_ERREN = 1;
  localparam int BIT_STAT  = 2;
endpackage

// File: rtl/dsc_dpath.sv
module dsc_dpath
  import dsc_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SHORT_LOG2 = 10,
  parameter int LONG_LOG2  = 15
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpCtrl_t ctrl,
  input  logic    useShort,
  output logic    atLimit
);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'((64'd1 << SHORT_LOG2) - 64'd1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'((64'd1 << LONG_LOG2) - 64'd1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] lastQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      lastQ <= LONG_LAST;
    end else if (ctrl.load) begin
      count <= '0;
      lastQ <= useShort ? SHORT_LAST : LONG_LAST;
    end else if (ctrl.advance) begin
      count <= count + 1'b1;
    end
  end

  assign atLimit = (count == lastQ);

  // count never passes the latched window end
  assert_count_in_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    count <= lastQ);

  // the window only changes on a fresh start
  assert_window_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(lastQ));
endmodule

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
  import dsc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    respArm,
  input  logic    respTaken,
  input  logic    atLimit,
  output dpCtrl_t dpCtrl,
  output logic    expire,
  output logic    discardPulse
);
  timerState_t state, nextState;

  always_comb begin
    dpCtrl    = '0;
    expire    = 1'b0;
    nextState = state;
    if (respTaken) begin
      nextState = ST_IDLE;
    end else if (respArm) begin
      dpCtrl.load = 1'b1;
      nextState   = ST_RUN;
    end else if (state == ST_RUN) begin
      if (atLimit) begin
        expire    = 1'b1;
        nextState = ST_IDLE;
      end else begin
        dpCtrl.advance = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      discardPulse <= 1'b0;
    end else begin
      state        <= nextState;
      discardPulse <= expire;
    end
  end

  assert_discard_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    discardPulse |=> !discardPulse);

  assert_idle_after_discard_R3: assert property (@(posedge clk) disable iff (!rstN)
    discardPulse |-> (state == ST_IDLE));

  assert_stop_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    respTaken |=> !discardPulse);

  assert_arm_restarts_R9: assert property (@(posedge clk) disable iff (!rstN)
    (respArm && !respTaken) |=> (state == ST_RUN && !discardPulse));
endmodule

// File: rtl/dsc_cfg.sv
module dsc_cfg
  import dsc_pkg::*;
(
  input  logic             clk,
  input  logic             pwrOkRstN,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [REG_W-1:0] cfgWrData,
  input  logic             expire,
  input  logic             globalSerrEn,
  output logic             useShort,
  output logic [REG_W-1:0] cfgRdData,
  output logic             sysErrReq
);
  logic shortQ, errEnQ, statusQ;

  // fields cleared by either reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shortQ    <= 1'b0;
      errEnQ    <= 1'b0;
      sysErrReq <= 1'b0;
    end else begin
      if (cfgWr) begin
        shortQ <= cfgWrData[BIT_SHORT];
        errEnQ <= cfgWrData[BIT_ERREN];
      end
      sysErrReq <= expire & errEnQ & globalSerrEn;
    end
  end

  // sticky flag, cleared only by power-good reset or write-one
  always_ff @(posedge clk or negedge pwrOkRstN) begin
    if (!pwrOkRstN)                        statusQ <= 1'b0;
    else if (expire)                       statusQ <= 1'b1;
    else if (cfgWr && cfgWrData[BIT_STAT]) statusQ <= 1'b0;
  end

  assign useShort  = shortQ;
  assign cfgRdData = {1'b0, statusQ, errEnQ, shortQ};

  assert_status_sets_R5: assert property (@(posedge clk) disable iff (!pwrOkRstN)
    expire |=> statusQ);

  assert_status_sticky_R5: assert property (@(posedge clk) disable iff (!pwrOkRstN)
    (statusQ && !(cfgWr && cfgWrData[BIT_STAT])) |=> statusQ);

  assert_serr_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !(errEnQ && globalSerrEn)) |=> !sysErrReq);
endmodule

// File: rtl/dly_resp_discard_timer.sv
module dly_resp_discard_timer
  import dsc_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SHORT_LOG2 = 10,
  parameter int LONG_LOG2  = 15
) (
  input  logic             clk,
  input  logic             pwrOkRstN,
  input  logic             busRstN,
  input  logic             respArm,
  input  logic             respTaken,
  input  logic             cfgWr,
  input  logic [REG_W-1:0] cfgWrData,
  output logic [REG_W-1:0] cfgRdData,
  input  logic             globalSerrEn,
  output logic             discardPulse,
  output logic             sysErrReq
);
  logic    rstN;
  dpCtrl_t dpCtrl;
  logic    atLimit;
  logic    expire;
  logic    useShort;

  assign rstN = pwrOkRstN & busRstN;

  dsc_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .respArm      (respArm),
    .respTaken    (respTaken),
    .atLimit      (atLimit),
    .dpCtrl       (dpCtrl),
    .expire       (expire),
    .discardPulse (discardPulse)
  );

  dsc_dpath #(
    .CNT_W      (CNT_W),
    .SHORT_LOG2 (SHORT_LOG2),
    .LONG_LOG2  (LONG_LOG2)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (dpCtrl),
    .useShort (useShort),
    .atLimit  (atLimit)
  );

  dsc_cfg u_cfg (
    .clk          (clk),
    .pwrOkRstN    (pwrOkRstN),
    .rstN         (rstN),
    .cfgWr        (cfgWr),
    .cfgWrData    (cfgWrData),
    .expire       (expire),
    .globalSerrEn (globalSerrEn),
    .useShort     (useShort),
    .cfgRdData    (cfgRdData),
    .sysErrReq    (sysErrReq)
  );

  assert_serr_with_discard_R7: assert property (@(posedge clk) disable iff (!rstN)
    sysErrReq |-> discardPulse);
endmodule

// File: tb/dly_resp_discard_timer_bench.sv
module dly_resp_discard_timer_bench;
  localparam int SL = 3;
  localparam int LL = 5;
  localparam int SHORT_LEN = 1 << SL;
  localparam int LONG_LEN  = 1 << LL;

  logic       clk = 1'b0;
  logic       pwrOkRstN = 1'b0, busRstN = 1'b0;
  logic       respArm = 1'b0, respTaken = 1'b0;
  logic       cfgWr = 1'b0;
  logic [3:0] cfgWrData = '0;
  logic [3:0] cfgRdData;
  logic       globalSerrEn = 1'b0;
  logic       discardPulse, sysErrReq;

  int  checks = 0;
  int  fails = 0;
  bit  done = 0;

  always #10 clk = ~clk;  // 50 MHz

  dly_resp_discard_timer #(.CNT_W(16), .SHORT_LOG2(SL), .LONG_LOG2(LL)) u_dly_resp_discard_timer (
    .clk(clk), .pwrOkRstN(pwrOkRstN), .busRstN(busRstN),
    .respArm(respArm), .respTaken(respTaken),
    .cfgWr(cfgWr), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .globalSerrEn(globalSerrEn),
    .discardPulse(discardPulse), .sysErrReq(sysErrReq)
  );

  // {select, errEn, globalEn, expected sysErrReq}
  localparam logic [3:0] VEC [6] = '{
    4'b1111, 4'b0111, 4'b1100, 4'b1010, 4'b0000, 4'b0100
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [3:0] d);
    cfgWr = 1'b1; cfgWrData = d;
    cyc();
    cfgWr = 1'b0; cfgWrData = '0;
  endtask

  // called just after the arm-sampling edge, startK edges already gone
  task automatic watch(input int startK, input int expLen, input logic expSerr, input string req);
    int seen = -1;
    int highs = 0;
    logic serrSeen = 1'b0;
    for (int k = startK + 1; k <= expLen + 2; k++) begin
      cyc();
      if (discardPulse) begin
        highs++;
        if (seen < 0) seen = k;
        serrSeen = sysErrReq;
      end
      if (sysErrReq && !discardPulse) serrSeen = 1'bx;
    end
    check({req, " expiry edge"}, 32'(seen), 32'(expLen));
    check("R3 single discard cycle", 32'(highs), 32'd1);
    check({"R7 serr ", req}, {31'd0, serrSeen}, {31'd0, expSerr});
  endtask

  task automatic armAndWatch(input int expLen, input logic expSerr, input string req);
    respArm = 1'b1;
    cyc();
    respArm = 1'b0;
    watch(0, expLen, expSerr, req);
  endtask

  initial begin
    repeat (3) cyc();
    pwrOkRstN = 1'b1; busRstN = 1'b1;
    cyc();
    // reset state
    check("R10 reset read", {28'd0, cfgRdData}, 32'h0);
    check("R10 reset discard", {31'd0, discardPulse}, 32'd0);
    check("R10 reset serr", {31'd0, sysErrReq}, 32'd0);

    // table walk
    for (int i = 0; i < 6; i++) begin
      logic [3:0] v = VEC[i];
      cfgWrite({1'b0, 1'b1, v[2], v[3]});
      globalSerrEn = v[1];
      armAndWatch(v[3] ? SHORT_LEN : LONG_LEN, v[0], v[3] ? "R1" : "R2");
      check("R5 status set", {31'd0, cfgRdData[2]}, 32'd1);
    end

    // R5 write-zero keeps, write-one clears
    cfgWrite(4'b0001);
    check("R5 write0 keeps", {28'd0, cfgRdData}, 32'h5);
    cfgWrite(4'b0101);
    check("R5 write1 clears", {28'd0, cfgRdData}, 32'h1);

    // R4 stop on the expiry cycle
    respArm = 1'b1; cyc(); respArm = 1'b0;
    repeat (SHORT_LEN - 1) cyc();
    respTaken = 1'b1; cyc(); respTaken = 1'b0;
    check("R4 stop at expiry", {31'd0, discardPulse}, 32'd0);
    begin
      int highs = 0;
      for (int k = 0; k < 2 * SHORT_LEN; k++) begin
        cyc();
        if (discardPulse) highs++;
      end
      check("R4 no later discard", 32'(highs), 32'd0);
    end
    check("R4 status untouched", {31'd0, cfgRdData[2]}, 32'd0);

    // R4 early stop
    respArm = 1'b1; cyc(); respArm = 1'b0;
    repeat (3) cyc();
    respTaken = 1'b1; cyc(); respTaken = 1'b0;
    begin
      int highs = 0;
      for (int k = 0; k < 2 * LONG_LEN; k++) begin
        cyc();
        if (discardPulse) highs++;
      end
      check("R4 early stop", 32'(highs), 32'd0);
    end

    // R9 re-arm restarts
    respArm = 1'b1; cyc(); respArm = 1'b0;
    repeat (5) cyc();
    armAndWatch(SHORT_LEN, 1'b0, "R9");

    // R9 arm on the expiry cycle restarts
    respArm = 1'b1; cyc(); respArm = 1'b0;
    repeat (SHORT_LEN - 1) cyc();
    respArm = 1'b1; cyc(); respArm = 1'b0;
    check("R9 arm beats expiry", {31'd0, discardPulse}, 32'd0);
    watch(0, SHORT_LEN, 1'b0, "R9 after collide");

    // R8 select change mid-count
    cfgWrite(4'b0101);
    respArm = 1'b1; cyc(); respArm = 1'b0;
    cfgWr = 1'b1; cfgWrData = 4'b0000;
    cyc();
    cfgWr = 1'b0;
    check("R8 select written", {31'd0, cfgRdData[0]}, 32'd0);
    watch(1, SHORT_LEN, 1'b0, "R8");
    armAndWatch(LONG_LEN, 1'b0, "R8 next start");

    // R6 bus reset keeps status, power-good clears it
    cfgWrite(4'b0011);
    check("R6 pre-reset", {28'd0, cfgRdData}, 32'h7);
    busRstN = 1'b0; cyc(); busRstN = 1'b1; cyc();
    check("R6 bus reset keeps status", {28'd0, cfgRdData}, 32'h4);
    pwrOkRstN = 1'b0; cyc(); pwrOkRstN = 1'b1; cyc();
    check("R6 power-good clears", {28'd0, cfgRdData}, 32'h0);

    // R6 bus reset mid-count cancels the count
    cfgWrite(4'b0001);
    respArm = 1'b1; cyc(); respArm = 1'b0;
    repeat (3) cyc();
    busRstN = 1'b0; cyc(); busRstN = 1'b1;
    begin
      int highs = 0;
      for (int k = 0; k < 2 * SHORT_LEN; k++) begin
        cyc();
        if (discardPulse) highs++;
      end
      check("R6 bus reset cancels", 32'(highs), 32'd0);
    end

    // R10 reserved bit reads zero
    cfgWrite(4'b1111);
    check("R10 layout", {28'd0, cfgRdData}, 32'h3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule